// File: doc/BRIEF.md
# Rotating-Priority Interrupt Request Resolver

This block is the core of one eight-line interrupt controller. It samples a level on every request line each clock and records it in a request register. Each line is either level-sensitive or edge-sensitive, chosen by a trigger-mode register. A mask register hides chosen requests from arbitration. An in-service register records interrupts that have been acknowledged and not yet ended. A rotating priority encoder picks the best unmasked request and compares it with the best in-service entry. The encoder counts priority positions from a rotation base supplied by the surrounding logic. It drives a registered interrupt output and the number of the winning line.

The surrounding logic handles several things outside this block: the register bus, the initialisation sequence, cascading of controllers and the choice of rotation base. It acknowledges the current winner with a one-cycle strobe. It ends service with either a named end-of-interrupt or one that retires the best in-service entry. When the instance is a cascade master and special nesting is on, an in-service entry on the cascade line does not block new requests. This lets a second controller behind that line nest its own interrupts.

Top module: `irq_resolver_core`

## Requirements
- R1: A clock edge with `rst` high clears the request, in-service, mask and trigger-mode registers and the remembered input levels, and drives `irq_out` and `irq_line` to 0.
- R2: For a line whose trigger-mode bit is 1 (level), the request bit after an edge equals the input level sampled at that edge. It is set while the input is high and cleared when the input is low.
- R3: For a line whose trigger-mode bit is 0 (edge), the request bit is set only when the sampled input is 1 and the level remembered from the previous edge is 0. A low input only updates the remembered level and leaves the request bit as it was.
- R4: `mask_wr` loads `mask_data` into the mask register. A request whose mask bit is 1 stays recorded in the request register but never wins arbitration.
- R5: Priority position p corresponds to line (p + `rot_base`) mod 8, and position 0 is the highest priority. `irq_line` reports (winning position + `rot_base`) mod 8.
- R6: When no unmasked request exists, `irq_out` is 0 and `irq_line` is 0.
- R7: An interrupt is signalled only when the best unmasked request is in a strictly better (smaller) position than the best in-service entry. An empty in-service set counts as position 8.
- R8: When `nest_master_en` is 1 on a master instance, in-service bit 2 (the cascade line) is left out of the in-service comparison.
- R9: `ack` while a winner exists sets that line's in-service bit and clears its request bit only if the line is edge-sensitive. `ack` with no winner changes nothing.
- R10: `eoi_wr` with `eoi_named` = 1 clears in-service bit `eoi_line`. With `eoi_named` = 0 it clears the in-service bit in the best position under the current rotation, ignoring the cascade exclusion. When `ack` and `eoi_wr` act on the same bit in one cycle, `ack` wins.
- R11: `irq_out` and `irq_line` are registers. They reflect the register state and the `rot_base` and `nest_master_en` inputs present at the previous edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_in | input | 8 | Request line levels |
| trig_wr | input | 1 | Load strobe for the trigger-mode register |
| trig_data | input | 8 | New trigger modes, 1 = level, 0 = edge |
| mask_wr | input | 1 | Load strobe for the mask register |
| mask_data | input | 8 | New mask, 1 = masked |
| ack | input | 1 | Acknowledge the current winner |
| eoi_wr | input | 1 | End-of-interrupt strobe |
| eoi_named | input | 1 | 1 = clear `eoi_line`, 0 = clear best in-service entry |
| eoi_line | input | 3 | Line cleared by a named end-of-interrupt |
| rot_base | input | 3 | Line that holds priority position 0 |
| nest_master_en | input | 1 | Exclude the cascade line from the in-service comparison |
| irq_out | output | 1 | Registered interrupt request |
| irq_line | output | 3 | Registered winning line number |
| irr_q | output | 8 | Request register |
| isr_q | output | 8 | In-service register |
| imr_q | output | 8 | Mask register |

## Verification
The assertions assume every input is synchronous to `clk` and settled before each rising edge. They also assume the request, mask and in-service state seen one cycle back is valid only after reset has been sampled at least once. The bench changes inputs only at falling edges and holds reset for whole cycles. It keeps `eoi_line` and `rot_base` within three bits, so every line index named by a strobe refers to a real line. Random traffic flips only a few request lines per cycle and issues acknowledge and end-of-interrupt strobes at moderate rates. This keeps nesting states, where in-service entries block later requests, reachable often.

// File: rtl/irq_resolver_pkg.sv
package irq_resolver_pkg;
  // Selects how an end-of-interrupt strobe picks its in-service bit.
  typedef enum logic {
    EOI_TOP_PRIO   = 1'b0,
    EOI_NAMED_LINE = 1'b1
  } eoi_kind_e;
endpackage

// File: rtl/irq_req_capture.sv
module irq_req_capture #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] req_in,
  input  logic [N-1:0] level_mode,
  input  logic [N-1:0] ack_clr,
  output logic [N-1:0] irr_q,
  output logic [N-1:0] last_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      irr_q  <= '0;
      last_q <= '0;
    end else begin
      last_q <= req_in;
      for (int i = 0; i < N; i++) begin
        if (level_mode[i]) begin
          irr_q[i] <= req_in[i];
        end else begin
          // a fresh rising edge in the acknowledge cycle is kept
          irr_q[i] <= (irr_q[i] & ~ack_clr[i]) | (req_in[i] & ~last_q[i]);
        end
      end
    end
  end
endmodule

// File: rtl/irq_rot_prio.sv
module irq_rot_prio #(
  parameter int N     = 8,
  parameter int IDX_W = 3,
  parameter int PRI_W = 4
) (
  input  logic [N-1:0]     vec,
  input  logic [IDX_W-1:0] base,
  output logic [PRI_W-1:0] pri,
  output logic [IDX_W-1:0] line
);
  logic [N-1:0] rotated;
  int           src;
  int           dst;

  always_comb begin
    rotated = '0;
    for (int p = 0; p < N; p++) begin
      src = p + int'(base);
      if (src >= N) src = src - N;
      rotated[p] = vec[src];
    end
    pri = PRI_W'(N);
    for (int p = N - 1; p >= 0; p--) begin
      if (rotated[p]) pri = PRI_W'(p);
    end
    dst = int'(pri) + int'(base);
    if (dst >= N) dst = dst - N;
    line = (pri == PRI_W'(N)) ? '0 : IDX_W'(dst);
  end
endmodule

// File: rtl/irq_resolver_core.sv
module irq_resolver_core
  import irq_resolver_pkg::*;
#(
  parameter int N            = 8,
  parameter int CASCADE_LINE = 2,
  parameter bit IS_MASTER    = 1'b1,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1,
  localparam int PRI_W = $clog2(N + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N-1:0]     req_in,
  input  logic             trig_wr,
  input  logic [N-1:0]     trig_data,
  input  logic             mask_wr,
  input  logic [N-1:0]     mask_data,
  input  logic             ack,
  input  logic             eoi_wr,
  input  logic             eoi_named,
  input  logic [IDX_W-1:0] eoi_line,
  input  logic [IDX_W-1:0] rot_base,
  input  logic             nest_master_en,
  output logic             irq_out,
  output logic [IDX_W-1:0] irq_line,
  output logic [N-1:0]     irr_q,
  output logic [N-1:0]     isr_q,
  output logic [N-1:0]     imr_q
);
  localparam logic [N-1:0] LSB_ONE = {{(N-1){1'b0}}, 1'b1};
  localparam logic [PRI_W-1:0] PRI_NONE = PRI_W'(N);

  logic [N-1:0]     trig_q, imr_r, isr_r, irr_w, last_w;
  logic [N-1:0]     pend, isr_cmp, ack_set, ack_clr_edge, eoi_clr;
  logic [PRI_W-1:0] pend_pri, cur_pri, top_pri;
  logic [IDX_W-1:0] win_line, cur_line, top_line;
  logic             win_valid;
  eoi_kind_e        eoi_kind;

  irq_req_capture #(.N(N)) u_cap (
    .clk(clk), .rst(rst), .req_in(req_in), .level_mode(trig_q),
    .ack_clr(ack_clr_edge), .irr_q(irr_w), .last_q(last_w)
  );

  assign pend = irr_w & ~imr_r;

  // cascade-line exclusion exists only on a master instance
  if (IS_MASTER) begin : g_master
    assign isr_cmp = nest_master_en ? (isr_r & ~(LSB_ONE << CASCADE_LINE)) : isr_r;
  end else begin : g_slave
    assign isr_cmp = isr_r;
  end

  irq_rot_prio #(.N(N), .IDX_W(IDX_W), .PRI_W(PRI_W)) u_pend_enc (
    .vec(pend), .base(rot_base), .pri(pend_pri), .line(win_line)
  );
  irq_rot_prio #(.N(N), .IDX_W(IDX_W), .PRI_W(PRI_W)) u_cur_enc (
    .vec(isr_cmp), .base(rot_base), .pri(cur_pri), .line(cur_line)
  );
  irq_rot_prio #(.N(N), .IDX_W(IDX_W), .PRI_W(PRI_W)) u_eoi_enc (
    .vec(isr_r), .base(rot_base), .pri(top_pri), .line(top_line)
  );

  assign win_valid    = (pend_pri < cur_pri);
  assign ack_set      = (ack && win_valid) ? (LSB_ONE << win_line) : '0;
  assign ack_clr_edge = ack_set & ~trig_q;
  assign eoi_kind     = eoi_kind_e'(eoi_named);

  always_comb begin
    eoi_clr = '0;
    if (eoi_wr) begin
      if (eoi_kind == EOI_NAMED_LINE) begin
        eoi_clr = LSB_ONE << eoi_line;
      end else if (top_pri != PRI_NONE) begin
        eoi_clr = LSB_ONE << top_line;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      trig_q   <= '0;
      imr_r    <= '0;
      isr_r    <= '0;
      irq_out  <= 1'b0;
      irq_line <= '0;
    end else begin
      if (trig_wr) trig_q <= trig_data;
      if (mask_wr) imr_r  <= mask_data;
      isr_r    <= (isr_r & ~eoi_clr) | ack_set;
      irq_out  <= win_valid;
      irq_line <= win_valid ? win_line : '0;
    end
  end

  assign irr_q = irr_w;
  assign isr_q = isr_r;
  assign imr_q = imr_r;
endmodule

// File: rtl/irq_resolver_checker.sv
module irq_resolver_checker #(
  parameter int N     = 8,
  parameter int IDX_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic [N-1:0]     req_in,
  input logic [N-1:0]     trig_q,
  input logic [N-1:0]     last_q,
  input logic [N-1:0]     irr_q,
  input logic [N-1:0]     imr_q,
  input logic [N-1:0]     isr_q,
  input logic             ack,
  input logic             win_valid,
  input logic [IDX_W-1:0] win_line,
  input logic             irq_out,
  input logic [IDX_W-1:0] irq_line
);
  localparam logic [N-1:0] LSB_ONE = {{(N-1){1'b0}}, 1'b1};

  assert_level_follows_R2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((irr_q & $past(trig_q)) == ($past(req_in) & $past(trig_q))));

  assert_edge_needs_rise_R3: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((irr_q & ~$past(irr_q) & ~$past(trig_q)
               & ~($past(req_in) & ~$past(last_q))) == '0));

  assert_winner_unmasked_R4: assert property (@(posedge clk) disable iff (rst)
    irq_out |-> ((($past(irr_q) & ~$past(imr_q)) & (LSB_ONE << irq_line)) != '0));

  assert_idle_line_zero_R6: assert property (@(posedge clk) disable iff (rst)
    !irq_out |-> (irq_line == '0));

  assert_ack_sets_isr_R9: assert property (@(posedge clk) disable iff (rst)
    (ack && win_valid) |=> isr_q[$past(win_line)]);

  assert_irq_tracks_resolver_R11: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq_out == $past(win_valid)));
endmodule

bind irq_resolver_core irq_resolver_checker #(.N(N), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst(rst), .req_in(req_in), .trig_q(trig_q), .last_q(last_w),
  .irr_q(irr_w), .imr_q(imr_r), .isr_q(isr_r), .ack(ack),
  .win_valid(win_valid), .win_line(win_line),
  .irq_out(irq_out), .irq_line(irq_line)
);

// File: tb/irq_resolver_core_test.sv
`timescale 1ns/1ps
module irq_resolver_core_test;
  logic       clk = 1'b0;
  logic       rst;
  logic [7:0] req_in, trig_data, mask_data;
  logic       trig_wr, mask_wr, ack, eoi_wr, eoi_named, nest_master_en;
  logic [2:0] eoi_line, rot_base;
  logic       irq_out;
  logic [2:0] irq_line;
  logic [7:0] irr_q, isr_q, imr_q;

  always #2.5 clk = ~clk;

  irq_resolver_core uut (
    .clk(clk), .rst(rst), .req_in(req_in), .trig_wr(trig_wr), .trig_data(trig_data),
    .mask_wr(mask_wr), .mask_data(mask_data), .ack(ack), .eoi_wr(eoi_wr),
    .eoi_named(eoi_named), .eoi_line(eoi_line), .rot_base(rot_base),
    .nest_master_en(nest_master_en), .irq_out(irq_out), .irq_line(irq_line),
    .irr_q(irr_q), .isr_q(isr_q), .imr_q(imr_q)
  );

  int    total = 0;
  int    fails = 0;
  bit    done  = 0;
  string cur_tag = "R1";

  logic [7:0] m_irr, m_isr, m_imr, m_trig, m_last;
  logic       m_irq;
  logic [2:0] m_line;

  function automatic int prio(logic [7:0] v, int r);
    for (int p = 0; p < 8; p++) if (v[(p + r) % 8]) return p;
    return 8;
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic model_step();
    int pp, cp, tp, wl, r;
    logic [7:0] cm, aset, eclr, nirr;
    logic valid;
    if (rst) begin
      m_irr = 0; m_isr = 0; m_imr = 0; m_trig = 0; m_last = 0; m_irq = 0; m_line = 0;
    end else begin
      r  = int'(rot_base);
      pp = prio(m_irr & ~m_imr, r);
      cm = m_isr;
      if (nest_master_en) cm[2] = 1'b0;
      cp = prio(cm, r);
      valid = (pp < cp);
      wl = (pp + r) % 8;
      aset = (ack && valid) ? (8'h01 << wl) : 8'h00;
      eclr = 8'h00;
      if (eoi_wr) begin
        if (eoi_named) eclr = 8'h01 << eoi_line;
        else begin
          tp = prio(m_isr, r);
          if (tp < 8) eclr = 8'h01 << ((tp + r) % 8);
        end
      end
      for (int i = 0; i < 8; i++)
        nirr[i] = m_trig[i] ? req_in[i]
                            : ((m_irr[i] & ~aset[i]) | (req_in[i] & ~m_last[i]));
      m_irr  = nirr;
      m_last = req_in;
      m_isr  = (m_isr & ~eclr) | aset;
      if (mask_wr) m_imr  = mask_data;
      if (trig_wr) m_trig = trig_data;
      m_irq  = valid;
      m_line = valid ? 3'(wl) : 3'd0;
    end
  endtask

  task automatic cycle();
    model_step();
    @(posedge clk);
    @(negedge clk);
    chk(cur_tag, "irr", irr_q, m_irr);
    chk(cur_tag, "isr", isr_q, m_isr);
    chk(cur_tag, "imr", imr_q, m_imr);
    chk(cur_tag, "irq_out", irq_out, m_irq);
    chk(cur_tag, "irq_line", irq_line, m_line);
    trig_wr = 0; mask_wr = 0; ack = 0; eoi_wr = 0;
  endtask

  task automatic do_reset();
    rst = 1; req_in = 0; rot_base = 0; nest_master_en = 0;
    cycle();
    rst = 0;
  endtask

  initial begin
    #900000;
    if (!done) begin
      total++; fails++;
      $display("FAIL R11 watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7341));
    rst = 1; req_in = 8'hFF; trig_wr = 0; trig_data = 0; mask_wr = 0; mask_data = 0;
    ack = 0; eoi_wr = 0; eoi_named = 0; eoi_line = 0; rot_base = 0; nest_master_en = 0;
    @(negedge clk);
    // R1: reset clears everything
    cur_tag = "R1";
    cycle(); cycle();
    chk("R1", "irr", irr_q, 0); chk("R1", "isr", isr_q, 0);
    chk("R1", "imr", imr_q, 0); chk("R1", "irq_out", irq_out, 0);
    chk("R1", "irq_line", irq_line, 0);
    req_in = 0; rst = 0; cycle();

    // R3: edge capture persists after the line drops
    cur_tag = "R3";
    req_in = 8'h10; cycle(); chk("R3", "irr set", irr_q, 8'h10);
    req_in = 8'h00; cycle(); chk("R3", "irr held", irr_q, 8'h10);
    chk("R5", "irq_out", irq_out, 1); chk("R5", "irq_line", irq_line, 4);

    // R4: masked request stays recorded but is not signalled
    cur_tag = "R4";
    mask_wr = 1; mask_data = 8'h10; cycle(); cycle();
    chk("R4", "irq_out", irq_out, 0); chk("R4", "irr", irr_q, 8'h10);

    // R2: level line follows input
    cur_tag = "R2";
    trig_wr = 1; trig_data = 8'h40; cycle();
    req_in = 8'h40; cycle(); chk("R2", "irr high", irr_q, 8'h50);
    req_in = 8'h00; cycle(); chk("R2", "irr low", irr_q, 8'h10);

    // R5: rotation decides between lines 1 and 5
    cur_tag = "R5";
    do_reset();
    rot_base = 3'd3; req_in = 8'h22; cycle();
    req_in = 8'h00; cycle(); chk("R5", "rot3 line", irq_line, 5);
    rot_base = 3'd0; cycle(); chk("R5", "rot0 line", irq_line, 1);

    // R9 and R7: acknowledge then nesting
    cur_tag = "R9";
    ack = 1; cycle();
    chk("R9", "isr", isr_q, 8'h02); chk("R9", "irr", irr_q, 8'h20);
    cur_tag = "R7";
    cycle(); chk("R7", "lower blocked", irq_out, 0);
    req_in = 8'h01; cycle(); req_in = 8'h00; cycle();
    chk("R7", "higher irq", irq_out, 1); chk("R7", "higher line", irq_line, 0);

    // R10: end of interrupt in both kinds, R9 ignored acknowledge
    cur_tag = "R10";
    eoi_wr = 1; eoi_named = 0; cycle(); chk("R10", "top eoi", isr_q, 8'h00);
    ack = 1; cycle(); chk("R9", "isr line0", isr_q, 8'h01);
    ack = 1; cycle(); chk("R9", "ack no winner", isr_q, 8'h01);
    chk("R9", "irr kept", irr_q, 8'h20);
    eoi_wr = 1; eoi_named = 1; eoi_line = 3'd0; cycle();
    chk("R10", "named eoi", isr_q, 8'h00);

    // R8: cascade line excluded from in-service comparison
    cur_tag = "R8";
    do_reset();
    req_in = 8'h04; cycle(); req_in = 8'h00; cycle();
    ack = 1; cycle(); chk("R8", "isr cascade", isr_q, 8'h04);
    req_in = 8'h0C; cycle(); req_in = 8'h00; cycle();
    chk("R8", "blocked", irq_out, 0);
    nest_master_en = 1; cycle();
    chk("R8", "nested irq", irq_out, 1); chk("R8", "nested line", irq_line, 2);

    // R6: idle outputs
    cur_tag = "R6";
    do_reset(); cycle();
    chk("R6", "irq_out", irq_out, 0); chk("R6", "irq_line", irq_line, 0);

    // R11: random traffic against the cycle model
    cur_tag = "R11";
    for (int n = 0; n < 4000; n++) begin
      req_in    = req_in ^ 8'($urandom & $urandom & $urandom);
      ack       = ($urandom % 4) == 0;
      eoi_wr    = ($urandom % 5) == 0;
      eoi_named = $urandom % 2;
      eoi_line  = 3'($urandom);
      if (($urandom % 16) == 0) begin mask_wr = 1; mask_data = 8'($urandom & $urandom); end
      if (($urandom % 32) == 0) begin trig_wr = 1; trig_data = 8'($urandom); end
      if (($urandom % 8) == 0)  rot_base = 3'($urandom);
      if (($urandom % 16) == 0) nest_master_en = ~nest_master_en;
      rst = (($urandom % 997) == 0);
      cycle();
      rst = 0;
    end

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule